// File: doc/BRIEF.md
# Fractional Microsecond Time Base

This block derives a one-microsecond time base from a reference clock that need not be an integer multiple of 1 MHz. A fractional prescaler adds a programmable numerator into an accumulator on every reference cycle. Each time the accumulated value reaches the programmed denominator, the denominator is taken back out and a single-cycle tick is raised. Reference clocks of 12, 13, 19.2 and 26 MHz therefore give an exact 1 MHz average, with no drift from rounding a divide ratio.

The tick drives a free-running microsecond counter. It is also driven out on `tick_o`, so neighbouring timers can use it as a clock enable. A small register port has separate read and write strobes, a byte-offset address and 32-bit data. Through it software sets the ratio, reads the counter, and can freeze the time base.

Top module: `utb_timebase`

## Requirements
- R1: After reset the ratio register (offset 0x14) reads 0x0000000B, the freeze register (offset 0x4C) reads 0, the counter (offset 0x10) reads 0, and `tick_o` is low.
- R2: The ratio register holds the denominator minus one in bits [7:0] and the numerator minus one in bits [15:8]. With numerator ≤ denominator, N running cycles after an accumulator clear advance the counter by floor(N·numerator/denominator). The settings 0x000B, 0x000C, 0x045F and 0x0019 give exactly 1,000,000 increments per second from 12, 13, 19.2 and 26 MHz.
- R3: `tick_o` is high for exactly one cycle per counter increment, so the number of tick cycles in a window equals the counter advance over that window.
- R4: When the numerator exceeds the denominator, the tick is raised on every running cycle.
- R5: While bit 0 of the freeze register is 1, the counter and the prescaler phase hold and `tick_o` stays low. The phase carries over unchanged when the freeze is lifted.
- R6: Every write to the ratio register clears the prescaler accumulator, which restarts the fractional phase.
- R7: Writes to the counter offset are ignored.
- R8: The counter wraps from all ones to zero with no flag, and counts modulo 2^CNT_W.
- R9: A read returns data on `rdata_o` in the cycle after `rd_en_i`. The data is the value held before that clock edge, and `rdata_o` holds between reads. Unmapped offsets read 0. Ratio bits above 15 read 0, and freeze bits above 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| tick_o | output | 1 | 1 MHz single-cycle tick enable |

## Verification
Two things can happen in the same cycle: a counter increment and a read of that counter. To provoke this, the ratio is set so the block ticks on every cycle, and the counter is then read on consecutive cycles. Each result must exceed the one before it by exactly one, which shows that a read returns the value from before that edge. Freeze windows are also opened and closed at exactly counted edges. The counter advance and the number of observed tick cycles must both match floor(N·numerator/denominator), for every supported reference clock and for a sweep of small ratios.

// File: rtl/utb_pkg.sv
package utb_pkg;
  localparam int unsigned FRAC_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CFG_W  = 2 * FRAC_W;

  // byte offsets decoded by the register port
  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_RATIO  = 8'h14;
  localparam logic [7:0] OFS_FREEZE = 8'h4C;

  localparam logic [CFG_W-1:0] RATIO_RESET = 16'h000B;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;  // numerator minus one, bits [15:8]
    logic [FRAC_W-1:0] den_m1;  // denominator minus one, bits [7:0]
  } ratio_cfg_t;
endpackage

// File: rtl/utb_rst_sync.sv
module utb_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/utb_frac_prescaler.sv
module utb_frac_prescaler
  import utb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  ratio_cfg_t cfg_i,
  output logic       tick_o
);
  localparam int unsigned ACC_W = FRAC_W + 2;

  logic [ACC_W-1:0] num, den, sum, rem;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             hit;

  always_comb begin
    num = ACC_W'(cfg_i.num_m1) + ACC_W'(1);
    den = ACC_W'(cfg_i.den_m1) + ACC_W'(1);
    sum = acc_q + num;
    hit = (sum >= den);
    rem = sum - den;
  end

  always_comb begin
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (run_i) begin
      if (hit) acc_d = (rem >= den) ? (den - ACC_W'(1)) : rem;  // clamp for num > den
      else     acc_d = sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign tick_o = run_i & hit;

  // R2: the phase never reaches the denominator
  p_acc_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < den);

  // R6: a ratio write leaves the phase at zero
  p_clear_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));

  // R5: a stopped prescaler keeps its phase
  p_phase_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/utb_us_counter.sv
module utb_us_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = cnt_q + CNT_W'(1);  // wraps silently
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R3/R8: every step adds one, modulo the width
  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: no step, no change
  p_no_step_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/utb_reg_port.sv
module utb_reg_port
  import utb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_o,
  output ratio_cfg_t        cfg_o,
  output logic              freeze_o,
  output logic              cfg_wr_o
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_RATIO  = ADDR_W'(OFS_RATIO);
  localparam logic [ADDR_W-1:0] A_FREEZE = ADDR_W'(OFS_FREEZE);

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              frz_q, frz_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_val;
  logic              sel_ratio, sel_freeze, sel_count;

  always_comb begin
    sel_ratio  = (addr_i == A_RATIO);
    sel_freeze = (addr_i == A_FREEZE);
    sel_count  = (addr_i == A_COUNT);
    cfg_wr_o   = wr_en_i & sel_ratio;

    cfg_d = cfg_q;
    if (cfg_wr_o) cfg_d = wdata_i[CFG_W-1:0];
    frz_d = frz_q;
    if (wr_en_i && sel_freeze) frz_d = wdata_i[0];

    if (sel_count)       rd_val = DATA_W'(count_i);
    else if (sel_ratio)  rd_val = DATA_W'(cfg_q);
    else if (sel_freeze) rd_val = DATA_W'(frz_q);
    else                 rd_val = '0;

    rdata_d = rd_en_i ? rd_val : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= RATIO_RESET;
      frz_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      frz_q   <= frz_d;
      rdata_q <= rdata_d;
    end
  end

  assign cfg_o    = ratio_cfg_t'(cfg_q);
  assign freeze_o = frz_q;
  assign rdata_o  = rdata_q;

  // R9: read data only moves after a read strobe
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R9: upper ratio bits never appear
  p_ratio_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_ratio) |=> (rdata_o[DATA_W-1:CFG_W] == '0));
endmodule

// File: rtl/utb_timebase.sv
module utb_timebase
  import utb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tick_o
);
  logic             rst_n;
  logic             frozen, cfg_wr, tick;
  ratio_cfg_t       cfg;
  logic [CNT_W-1:0] count;

  utb_rst_sync i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  utb_reg_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_reg_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .count_i  (count),
    .rdata_o  (rdata_o),
    .cfg_o    (cfg),
    .freeze_o (frozen),
    .cfg_wr_o (cfg_wr)
  );

  utb_frac_prescaler i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (!frozen),
    .clr_i  (cfg_wr),
    .cfg_i  (cfg),
    .tick_o (tick)
  );

  utb_us_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .step_i  (tick),
    .count_o (count)
  );

  assign tick_o = tick;

  // R5: a frozen time base keeps its count
  p_frozen_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    frozen |=> $stable(count));

  // R5: a frozen time base is silent
  p_frozen_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    frozen |-> !tick_o);
endmodule

// File: tb/test_utb_timebase.sv
module test_utb_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int MASK = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        rd_en, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        tick;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utb_timebase #(.ADDR_W(8), .CNT_W(CW)) i_utb_timebase (
    .clk_i(clk), .arst_ni(arst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
  );

  always @(negedge clk) if (tick === 1'b1) tick_cnt = tick_cnt + 1;

  task automatic check_eq(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic int model(input int cfg, input int n);
    int num = ((cfg >> 8) & 255) + 1;
    int den = (cfg & 255) + 1;
    return (num > den) ? n : (n * num) / den;
  endfunction

  // assumes frozen on entry; leaves frozen; runs exactly n edges
  task automatic window(input int cfg, input bit do_cfg, input int n,
                        input int exp, input string req,
                        output logic [31:0] c0, output logic [31:0] c1);
    if (do_cfg) bus_wr(8'h14, cfg);
    bus_rd(8'h10, c0);
    tick_cnt = 0;
    bus_wr(8'h4C, 32'd0);
    repeat (n - 1) @(negedge clk);
    bus_wr(8'h4C, 32'd1);
    bus_rd(8'h10, c1);
    check_eq(req, int'((c1 - c0) & MASK), exp & MASK);
    check_eq({req, "/R3 ticks"}, tick_cnt, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0, c1, prev;
    int cfgs[4] = '{32'h000B, 32'h000C, 32'h045F, 32'h0019};
    rd_en = 0; wr_en = 0; addr = 0; wdata = 0; arst_n = 0;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_eq("R1 tick low", int'(tick), 0);
    bus_rd(8'h14, v); check_eq("R1 ratio", int'(v), 32'h0B);
    bus_rd(8'h4C, v); check_eq("R1 freeze", int'(v), 0);
    bus_rd(8'h10, v); check_eq("R1 count", int'(v), 0);
    bus_wr(8'h4C, 32'd1);

    // R9 read decode
    bus_rd(8'h20, v); check_eq("R9 unmapped", int'(v), 0);
    bus_wr(8'h14, 32'hABCD1234);
    bus_rd(8'h14, v); check_eq("R9 ratio upper bits", int'(v), 32'h1234);
    bus_wr(8'h4C, 32'hFFFF_FFFF);
    bus_rd(8'h4C, v); check_eq("R9 freeze upper bits", int'(v), 1);

    // R7 counter write ignored
    bus_rd(8'h10, c0);
    bus_wr(8'h10, 32'h0000_0ABC);
    bus_rd(8'h10, c1); check_eq("R7 count unchanged", int'(c1), int'(c0));

    // R6 / R5 phase restart and phase hold across freeze (12 cycles per tick)
    window(32'h000B, 1, 7, 0, "R6 first", c0, c1);
    window(32'h000B, 0, 7, 1, "R5 phase kept", c0, c1);
    window(32'h000B, 1, 7, 0, "R6 phase cleared", c0, c1);

    // R2 supported reference clocks
    foreach (cfgs[i]) begin
      int den = (cfgs[i] & 255) + 1;
      int ns[5] = '{1, den - 1, den, 2 * den + 1, 19200};
      foreach (ns[j]) begin
        if (ns[j] >= 1) window(cfgs[i], 1, ns[j], model(cfgs[i], ns[j]), "R2 rate", c0, c1);
      end
    end

    // R2 / R4 sweep of small ratios
    for (int nm = 0; nm < 4; nm++) begin
      for (int dn = 0; dn < 6; dn++) begin
        int cfg = (nm << 8) | dn;
        window(cfg, 1, 29, model(cfg, 29), (nm > dn) ? "R4 every cycle" : "R2 sweep", c0, c1);
      end
    end

    // R8 wrap: exactly 2^CW increments lands on the same value
    window(32'h0000, 1, 1 << CW, 1 << CW, "R8 wrap", c0, c1);
    check_eq("R8 wrapped equal", int'(c1), int'(c0));

    // R9 read coincides with increment: one tick per cycle
    bus_wr(8'h14, 32'h0000);
    bus_wr(8'h4C, 32'd0);
    bus_rd(8'h10, prev);
    for (int k = 0; k < 6; k++) begin
      bus_rd(8'h10, v);
      check_eq("R9 pre-edge value", int'((v - prev) & MASK), 1);
      prev = v;
    end
    bus_wr(8'h4C, 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule